// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the host-facing control port of an audio codec. The host sees four byte-wide direct locations: an index pointer, a data window, a status byte and a programmed-I/O byte. The data window reaches one of 32 indirect 8-bit control registers, selected by the index pointer. How many index bits are used depends on an extended-mode bit held in one of the indirect registers.

The port owns the reset contents of the whole bank. It applies the write protections: read-only and reserved slots, a single writable bit in the mode register, and a forced-zero bit in the configuration register. It gates writes to the playback format register behind a mode-change enable held in the index pointer. A secondary path accepts only the upper nibble of a format write, and it is open while a playback interrupt is pending.

The port keeps an interrupt flag. A pulse from the playback engine sets it. A write to the status byte clears it, and so does a write that drops the pending bit in the alternate status register. Downstream logic gets three things: the current format byte, a one-cycle strobe when the format should be reloaded, and the playback-enable level.

Top module: `codec_regport`

## Requirements
- R1: Direct address 0 is the index pointer, 1 the indirect data window, 2 status (bit 0 = interrupt flag, others 0) and 3 programmed-I/O data, which reads 0 and ignores writes.
- R2: Bit 7 of the index pointer is never stored and reads 0. After reset the pointer holds 0x40, with bit 6 (mode-change enable) set.
- R3: When bit 6 of indirect register 12 is 0, the indirect index is pointer bits [3:0]. When it is 1, the index is pointer bits [4:0].
- R4: Reset contents: 0x88 at indices 2, 3, 4, 5, 18 and 19; 0x80 at 6 and 7; 0x08 at 9; 0x8A at 12; 0xA0 at 25 and 26; 0x00 everywhere else. After reset the outputs are irqOut=0, playEnable=0, fmtLoad=0 and fmtByte=0.
- R5: A write to index 8 while pointer bit 6 is set stores the whole byte. Otherwise, while bit 4 of index 24 is set, it stores only the upper nibble and keeps the old lower nibble. Otherwise it is discarded. An accepted write pulses fmtLoad for the cycle after the write, with fmtByte already updated.
- R6: Writes to indices 11, 22, 27 and 29 leave those registers unchanged.
- R7: A write to index 12 changes only bit 6. A write to index 9 always stores bit 5 as 0.
- R8: Any write to address 2 clears the interrupt flag and irqOut, and clears bits 6:4 of index 24.
- R9: A write to index 24 that takes bit 4 from 1 to 0 clears the interrupt flag and irqOut. A write that keeps bit 4 at 1 leaves them set.
- R10: When pointer bit 6 rises from 0 to 1 through a pointer write while index 9 bits [4:3] are not both 0, a counter loads ACK_READS. Each data-window read of index 11 while the counter is nonzero returns bit 5 set and decrements the counter.
- R11: playEnable equals bit 0 of index 9. A write that takes that bit from 0 to 1 pulses fmtLoad in the following cycle.
- R12: A playIrqSet pulse sets the interrupt flag, irqOut and bit 4 of index 24. If it coincides with a clearing write, the set wins.
- R13: Read data is registered: rdData presents the addressed value in the cycle after rdEn and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one byte |
| rdEn | input | 1 | Read strobe for one byte |
| addr | input | 2 | Direct address |
| wrData | input | 8 | Write byte |
| playIrqSet | input | 1 | Playback-complete pulse from the sample engine |
| rdData | output | 8 | Registered read byte |
| irqOut | output | 1 | Interrupt request level |
| fmtByte | output | 8 | Current playback format register |
| fmtLoad | output | 1 | One-cycle format reload strobe |
| playEnable | output | 1 | Playback enable level |

## Verification
The bench goes after several corner cases.

- Index width after the extended-mode bit toggles: a port that ignored the mode bit would read register 24 when it should alias to register 8.
- The format register's three outcomes: full store, upper nibble only, and discard. A port that skipped the nibble merge would corrupt the sample-rate bits. A port that missed the gate would accept writes while the mode-change enable is off.
- The acknowledge counter on index 11: its load must happen only on a rising mode-change enable, and its count must be exact, or the host's calibration wait would hang or end early.
- Collisions between the interrupt set pulse and a clearing write: getting these wrong would lose a playback-complete interrupt.

// File: rtl/codec_regport_pkg.sv
package codec_regport_pkg;

  localparam int NUM_REGS = 32;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam logic [IDX_W-1:0] IDX_FMT  = 5'd8;
  localparam logic [IDX_W-1:0] IDX_CFG  = 5'd9;
  localparam logic [IDX_W-1:0] IDX_ERR  = 5'd11;
  localparam logic [IDX_W-1:0] IDX_MODE = 5'd12;
  localparam logic [IDX_W-1:0] IDX_RSV0 = 5'd22;
  localparam logic [IDX_W-1:0] IDX_ALT  = 5'd24;
  localparam logic [IDX_W-1:0] IDX_RSV1 = 5'd27;
  localparam logic [IDX_W-1:0] IDX_RSV2 = 5'd29;

  // Strobes handed from the control section to the register bank
  typedef struct packed {
    logic             bankWr;
    logic [IDX_W-1:0] bankIdx;
    logic [7:0]       wrByte;
    logic             mce;
    logic             statClr;
    logic             pendSet;
  } bankCtl_t;

  function automatic logic [7:0] resetByte(input int i);
    case (i)
      2, 3, 4, 5, 18, 19: resetByte = 8'h88;
      6, 7:               resetByte = 8'h80;
      9:                  resetByte = 8'h08;
      12:                 resetByte = 8'h8A;
      25, 26:             resetByte = 8'hA0;
      default:            resetByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/codec_regport_bank.sv
module codec_regport_bank
  import codec_regport_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  bankCtl_t       ctl,
  output logic [7:0]     rdByte,
  output logic           mode2,
  output logic           ackArm,
  output logic           pendFall,
  output logic [7:0]     fmtByte,
  output logic           fmtLoad,
  output logic           playEnable
);

  logic [7:0] regs [NUM_REGS];
  logic [7:0] wrVal;
  logic [7:0] altNext;
  logic       wrAccept;
  logic       fmtAccept;
  logic       fmtPulse;
  logic       playPrev;

  always_comb begin
    wrAccept  = ctl.bankWr;
    fmtAccept = 1'b0;
    wrVal     = ctl.wrByte;
    case (ctl.bankIdx)
      IDX_ERR, IDX_RSV0, IDX_RSV1, IDX_RSV2: wrAccept = 1'b0;
      IDX_FMT: begin
        if (ctl.mce) begin
          fmtAccept = ctl.bankWr;
        end else if (regs[IDX_ALT][4]) begin
          wrVal     = {ctl.wrByte[7:4], regs[IDX_FMT][3:0]};
          fmtAccept = ctl.bankWr;
        end else begin
          wrAccept = 1'b0;
        end
      end
      IDX_CFG:  wrVal[5] = 1'b0;
      IDX_MODE: wrVal = {regs[IDX_MODE][7], ctl.wrByte[6], regs[IDX_MODE][5:0]};
      default:  ;
    endcase
  end

  always_comb begin
    altNext = (wrAccept && ctl.bankIdx == IDX_ALT) ? wrVal : regs[IDX_ALT];
    if (ctl.statClr) altNext[6:4] = 3'b000;
    if (ctl.pendSet) altNext[4] = 1'b1;
  end

  assign pendFall = wrAccept && (ctl.bankIdx == IDX_ALT) &&
                    regs[IDX_ALT][4] && !ctl.wrByte[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= resetByte(i);
      fmtPulse <= 1'b0;
      playPrev <= 1'b0;
    end else begin
      if (wrAccept) regs[ctl.bankIdx] <= wrVal;
      if (ctl.statClr || ctl.pendSet) regs[IDX_ALT] <= altNext;
      fmtPulse <= fmtAccept;
      playPrev <= regs[IDX_CFG][0];
    end
  end

  assign rdByte     = regs[ctl.bankIdx];
  assign mode2      = regs[IDX_MODE][6];
  assign ackArm     = |regs[IDX_CFG][4:3];
  assign fmtByte    = regs[IDX_FMT];
  assign playEnable = regs[IDX_CFG][0];
  assign fmtLoad    = fmtPulse | (regs[IDX_CFG][0] & ~playPrev);

endmodule

// File: rtl/codec_regport_ctrl.sv
module codec_regport_ctrl
  import codec_regport_pkg::*;
#(
  parameter int ACK_READS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       playIrqSet,
  input  logic       mode2,
  input  logic       ackArm,
  input  logic       pendFall,
  input  logic [7:0] bankRd,
  output bankCtl_t   ctl,
  output logic [7:0] rdData,
  output logic       irqOut
);

  localparam int CNT_W = $clog2(ACK_READS + 1) + 1;

  logic [6:0]       indexReg;
  logic             intFlag;
  logic [CNT_W-1:0] ackCnt;
  logic [IDX_W-1:0] effIdx;
  logic             idxWr;
  logic             statWr;
  logic             ackLoad;
  logic             ackHit;
  logic [7:0]       rdMux;

  assign effIdx = mode2 ? indexReg[4:0] : {1'b0, indexReg[3:0]};
  assign idxWr  = wrEn && (addr == 2'd0);
  assign statWr = wrEn && (addr == 2'd2);

  assign ctl.bankWr  = wrEn && (addr == 2'd1);
  assign ctl.bankIdx = effIdx;
  assign ctl.wrByte  = wrData;
  assign ctl.mce     = indexReg[6];
  assign ctl.statClr = statWr;
  assign ctl.pendSet = playIrqSet;

  assign ackLoad = idxWr && !indexReg[6] && wrData[6] && ackArm;
  assign ackHit  = rdEn && (addr == 2'd1) && (effIdx == IDX_ERR) && (ackCnt != '0);

  always_comb begin
    case (addr)
      2'd0:    rdMux = {1'b0, indexReg};
      2'd1:    rdMux = bankRd | (ackHit ? 8'h20 : 8'h00);
      2'd2:    rdMux = {7'b0, intFlag};
      default: rdMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= 7'h40;
      intFlag  <= 1'b0;
      ackCnt   <= '0;
      rdData   <= 8'h00;
    end else begin
      if (idxWr) indexReg <= wrData[6:0];
      if (ackLoad)     ackCnt <= CNT_W'(ACK_READS);
      else if (ackHit) ackCnt <= ackCnt - 1'b1;
      if (playIrqSet)                intFlag <= 1'b1;
      else if (statWr || pendFall)   intFlag <= 1'b0;
      if (rdEn) rdData <= rdMux;
    end
  end

  assign irqOut = intFlag;

endmodule

// File: rtl/codec_regport.sv
module codec_regport
  import codec_regport_pkg::*;
#(
  parameter int ACK_READS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       playIrqSet,
  output logic [7:0] rdData,
  output logic       irqOut,
  output logic [7:0] fmtByte,
  output logic       fmtLoad,
  output logic       playEnable
);

  bankCtl_t   ctl;
  logic [7:0] bankRd;
  logic       mode2;
  logic       ackArm;
  logic       pendFall;

  codec_regport_ctrl #(.ACK_READS(ACK_READS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .playIrqSet(playIrqSet), .mode2(mode2),
    .ackArm(ackArm), .pendFall(pendFall), .bankRd(bankRd),
    .ctl(ctl), .rdData(rdData), .irqOut(irqOut)
  );

  codec_regport_bank u_bank (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdByte(bankRd), .mode2(mode2),
    .ackArm(ackArm), .pendFall(pendFall), .fmtByte(fmtByte),
    .fmtLoad(fmtLoad), .playEnable(playEnable)
  );

endmodule

// File: rtl/codec_regport_chk.sv
module codec_regport_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic [1:0] addr,
  input logic       playIrqSet,
  input logic [7:0] rdData,
  input logic       irqOut,
  input logic [7:0] fmtByte,
  input logic       fmtLoad,
  input logic       playEnable
);

  // R2
  idx_msb_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd0) |=> (rdData <= 8'h7F));

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd2 && !playIrqSet) |=> !irqOut);

  // R12
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    playIrqSet |=> irqOut);

  // R5
  fmt_change_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fmtByte) |-> fmtLoad);

  // R11
  play_rise_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(playEnable) |-> fmtLoad);

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind codec_regport codec_regport_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .playIrqSet(playIrqSet), .rdData(rdData), .irqOut(irqOut),
  .fmtByte(fmtByte), .fmtLoad(fmtLoad), .playEnable(playEnable)
);

// File: tb/codec_regport_tb.sv
`timescale 1ns/1ps
module codec_regport_tb;

  localparam int ACK = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic       playIrqSet = 1'b0;
  logic [7:0] rdData;
  logic       irqOut;
  logic [7:0] fmtByte;
  logic       fmtLoad;
  logic       playEnable;

  int checks = 0;
  int errors = 0;
  string curReq = "R4";

  logic [7:0] mBank [32];
  logic [6:0] mIdx;
  logic       mInt;
  int         mAck;

  always #2 clk = ~clk;

  codec_regport #(.ACK_READS(ACK)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .playIrqSet(playIrqSet), .rdData(rdData),
    .irqOut(irqOut), .fmtByte(fmtByte), .fmtLoad(fmtLoad),
    .playEnable(playEnable)
  );

  function automatic logic [7:0] expReset(input int i);
    if (i inside {2, 3, 4, 5, 18, 19}) return 8'h88;
    if (i == 6 || i == 7) return 8'h80;
    if (i == 9) return 8'h08;
    if (i == 12) return 8'h8A;
    if (i == 25 || i == 26) return 8'hA0;
    return 8'h00;
  endfunction

  function automatic int effIdx();
    return mBank[12][6] ? int'(mIdx[4:0]) : int'(mIdx[3:0]);
  endfunction

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", curReq, what, act, exp);
    end
  endtask

  task automatic chkOuts(input bit expLoad);
    chk("fmtLoad", {7'b0, fmtLoad}, {7'b0, expLoad});
    chk("fmtByte", fmtByte, mBank[8]);
    chk("playEnable", {7'b0, playEnable}, {7'b0, mBank[9][0]});
    chk("irqOut", {7'b0, irqOut}, {7'b0, mInt});
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d, input bit alsoSet);
    bit expLoad;
    int i;
    expLoad = 0;
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; playIrqSet = alsoSet;
    @(negedge clk);
    wrEn = 1'b0; playIrqSet = 1'b0;
    case (a)
      2'd0: begin
        if (!mIdx[6] && d[6] && mBank[9][4:3] != 2'b00) mAck = ACK;
        mIdx = d[6:0];
      end
      2'd1: begin
        i = effIdx();
        case (i)
          11, 22, 27, 29: ;
          8: begin
            if (mIdx[6]) begin mBank[8] = d; expLoad = 1; end
            else if (mBank[24][4]) begin mBank[8] = {d[7:4], mBank[8][3:0]}; expLoad = 1; end
          end
          9: begin
            if (!mBank[9][0] && d[0]) expLoad = 1;
            mBank[9] = d & 8'hDF;
          end
          12: mBank[12][6] = d[6];
          24: begin
            if (mBank[24][4] && !d[4]) mInt = 1'b0;
            mBank[24] = d;
          end
          default: mBank[i] = d;
        endcase
      end
      2'd2: begin mInt = 1'b0; mBank[24][6:4] = 3'b000; end
      default: ;
    endcase
    if (alsoSet) begin mInt = 1'b1; mBank[24][4] = 1'b1; end
    chkOuts(expLoad);
  endtask

  task automatic doPulse();
    @(negedge clk);
    playIrqSet = 1'b1;
    @(negedge clk);
    playIrqSet = 1'b0;
    mInt = 1'b1; mBank[24][4] = 1'b1;
    chkOuts(1'b0);
  endtask

  task automatic doRead(input logic [1:0] a);
    logic [7:0] exp;
    int i;
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    case (a)
      2'd0: exp = {1'b0, mIdx};
      2'd1: begin
        i = effIdx();
        exp = mBank[i];
        if (i == 11 && mAck > 0) begin exp = exp | 8'h20; mAck--; end
      end
      2'd2: exp = {7'b0, mInt};
      default: exp = 8'h00;
    endcase
    chk($sformatf("read addr %0d", a), rdData, exp);
  endtask

  task automatic rdIdx(input logic [7:0] ix);
    doWrite(2'd0, ix, 1'b0);
    doRead(2'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) mBank[i] = expReset(i);
    mIdx = 7'h40; mInt = 1'b0; mAck = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4: outputs and bank after reset
    curReq = "R4";
    chkOuts(1'b0);
    curReq = "R2";
    doRead(2'd0);
    curReq = "R4";
    for (int i = 0; i < 16; i++) rdIdx(8'(i) | 8'h40);
    curReq = "R3";
    doWrite(2'd0, 8'h4C, 1'b0);
    doWrite(2'd1, 8'hFF, 1'b0);   // R7: only bit 6 of index 12 changes
    curReq = "R4";
    for (int i = 16; i < 32; i++) rdIdx(8'(i) | 8'h40);

    // R3: dropping the mode bit folds index 24 onto 8
    curReq = "R3";
    rdIdx(8'h4C);
    doWrite(2'd1, 8'h00, 1'b0);
    rdIdx(8'h58);
    rdIdx(8'h5C);

    // R2: bit 7 of pointer is dropped
    curReq = "R2";
    doWrite(2'd0, 8'hFF, 1'b0);
    doRead(2'd0);

    // R1: programmed-I/O location
    curReq = "R1";
    doWrite(2'd3, 8'hA5, 1'b0);
    doRead(2'd3);
    doRead(2'd2);

    // R5: three outcomes of a format write
    curReq = "R5";
    doWrite(2'd0, 8'h48, 1'b0);
    doWrite(2'd1, 8'h5B, 1'b0);
    doWrite(2'd0, 8'h08, 1'b0);
    doWrite(2'd1, 8'h11, 1'b0);
    doRead(2'd1);
    doPulse();
    doWrite(2'd1, 8'h2F, 1'b0);
    doRead(2'd1);

    // R8: status write clears flag and pending bits
    curReq = "R8";
    doWrite(2'd2, 8'h00, 1'b0);
    doRead(2'd2);
    doWrite(2'd0, 8'h0C, 1'b0);
    doWrite(2'd1, 8'h40, 1'b0);
    doWrite(2'd0, 8'h18, 1'b0);
    doWrite(2'd1, 8'h70, 1'b0);
    doWrite(2'd2, 8'h00, 1'b0);
    doRead(2'd1);

    // R9: pending bit falling through a register write
    curReq = "R9";
    doPulse();
    doWrite(2'd1, 8'h13, 1'b0);
    doRead(2'd2);
    doWrite(2'd1, 8'h03, 1'b0);
    doRead(2'd2);

    // R6: protected slots
    curReq = "R6";
    rdIdx(8'h0B);
    doWrite(2'd1, 8'hFF, 1'b0);
    rdIdx(8'h0B);
    rdIdx(8'h16); doWrite(2'd1, 8'h5A, 1'b0); doRead(2'd1);
    rdIdx(8'h1B); doWrite(2'd1, 8'h5A, 1'b0); doRead(2'd1);
    rdIdx(8'h1D); doWrite(2'd1, 8'h5A, 1'b0); doRead(2'd1);

    // R7: configuration bit 5 forced low
    curReq = "R7";
    doWrite(2'd0, 8'h09, 1'b0);
    doWrite(2'd1, 8'h28, 1'b0);
    doRead(2'd1);

    // R10: acknowledge counter on index 11
    curReq = "R10";
    doWrite(2'd0, 8'h0B, 1'b0);
    doWrite(2'd0, 8'h4B, 1'b0);
    doRead(2'd1); doRead(2'd1); doRead(2'd1);
    doWrite(2'd0, 8'h4B, 1'b0);
    doRead(2'd1);

    // R11: playback enable and its reload strobe
    curReq = "R11";
    doWrite(2'd0, 8'h49, 1'b0);
    doWrite(2'd1, 8'h09, 1'b0);
    doWrite(2'd1, 8'h09, 1'b0);
    doWrite(2'd1, 8'h08, 1'b0);

    // R12: set beats a coincident clear
    curReq = "R12";
    doWrite(2'd2, 8'h00, 1'b1);
    doRead(2'd2);
    doWrite(2'd0, 8'h58, 1'b0);
    doWrite(2'd1, 8'h00, 1'b1);
    doRead(2'd2);

    // R13 plus all rules: random traffic
    curReq = "R13";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom % 10;
      if (r < 2)      doWrite(2'd0, 8'($urandom), 1'b0);
      else if (r < 5) doWrite(2'd1, 8'($urandom), 1'b0);
      else if (r < 6) doWrite(2'($urandom), 8'($urandom), 1'b0);
      else if (r < 9) doRead(2'($urandom));
      else            doPulse();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule